// File: doc/BRIEF.md
# Dual-Width Host Display Memory Port

This block sits between a host processor bus and a one-bit-per-pixel display memory sized for a 320 by 240 panel, 9600 bytes in total. The storage is built as two half-size banks: a low bank whose bytes travel on data bits 7:0 and a high bank whose bytes travel on data bits 15:8. Both banks are addressed by host address bits 13:1.

A mode pin chooses the host width. A byte-wide host sees one linear byte space, where address bit 0 picks the bank. A word-wide host can pick byte lanes in one of two ways. In the first, address bit 0 and an active-low high-byte enable choose the lanes, and the low write strobe writes them. In the second, both of those inputs are tied high, and separate low and high write strobes write each lane. The block decodes chip select, read and write strobes into per-bank requests. It returns read data on the correct lanes, together with one output-enable bit per lane that stands for the lane's tri-state control.

Writes take effect at the clock edge that samples the strobes. Read data and lane enables are registered, so they appear in the cycle after the read strobe is sampled.

Top module: `dual_width_vram_port`

## Requirements
- R1: While reset is high and in the first cycle after it, `lane_oe` is 2'b00 and `rdata` is 16'h0000.
- R2: With `wide_mode` low, a write with `wrl_n` low stores `wdata[7:0]` at byte address `addr`. Bank = `addr[0]` (0 low, 1 high), word = `addr[13:1]`. A read returns that byte on `rdata[7:0]` with `lane_oe` = 2'b01 and `rdata[15:8]` = 0. `bhe_n` and `wrh_n` have no effect in this mode, and only one bank is ever written.
- R3: The two widths share storage: word w read by a wide host shows byte address 2w on bits 7:0 and byte address 2w+1 on bits 15:8.
- R4: Wide mode, lane-select convention (`addr[0]` and `bhe_n` not both high): `addr[0]`=0 selects the low lane and `bhe_n`=0 selects the high lane. A write with `wrl_n` low writes only the selected lanes, from their own data bits, and leaves the other lane unchanged.
- R5: In the lane-select convention a read gives `lane_oe` = {!`bhe_n`, !`addr[0]`}. A lane whose enable bit is 0 reads as zero.
- R6: Wide mode, split-strobe convention (`addr[0]`=1 and `bhe_n`=1): `wrl_n` low writes the low bank and `wrh_n` low writes the high bank, each independently. A read enables both lanes, `lane_oe` = 2'b11.
- R7: With `cs_n` high, no location is written and the next cycle has `lane_oe` = 2'b00, whatever the strobes do.
- R8: A word index `addr[13:1]` at or above the bank depth (4800 by default) writes nothing. Reads of it give zero on the enabled lanes.
- R9: A read and a write to the same location in the same cycle return the old contents, and the write still lands.
- R10: `lane_oe` and `rdata` change only at the clock edge after the read strobe is sampled, and `lane_oe` returns to 2'b00 in the cycle after a cycle without a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wide_mode | input | 1 | 0 = byte-wide host, 1 = word-wide host |
| cs_n | input | 1 | Active-low memory select |
| rd_n | input | 1 | Active-low read strobe |
| wrl_n | input | 1 | Active-low write strobe, low lane (all writes in byte and lane-select use) |
| wrh_n | input | 1 | Active-low write strobe, high lane (split-strobe use) |
| bhe_n | input | 1 | Active-low high-byte enable |
| addr | input | 14 | Host byte address |
| wdata | input | 16 | Host write data |
| rdata | output | 16 | Read data, zero on disabled lanes |
| lane_oe | output | 2 | Per-lane read drive enable, bit 0 = bits 7:0, bit 1 = bits 15:8 |

## Verification
A read and a write can land on the same bank word in one cycle. The bench provokes this in split-strobe mode by holding `rd_n`, `wrl_n` and `wrh_n` low together on a word it already holds in its model. It expects the old word in that cycle and the new word on a following read. The bench also keeps a byte-array model and sweeps every byte address, every lane selection of both wide conventions and a band of out-of-range addresses. It judges each readback against that model.

// File: rtl/vram_port_pkg.sv
package vram_port_pkg;

    localparam int LANE_W = 8;
    localparam int NUM_LANES = 2;

    typedef enum logic [1:0] {
        ACC_BYTE   = 2'd0,
        ACC_LANES  = 2'd1,
        ACC_SPLIT  = 2'd2
    } access_kind_e;

    typedef struct packed {
        logic              we;
        logic              re;
        logic [LANE_W-1:0] wd;
    } bank_req_t;

    typedef struct packed {
        logic [NUM_LANES-1:0] oe;
        logic                 swap;
    } route_t;

    function automatic access_kind_e classify(input logic wide, input logic a0, input logic bhe_n);
        if (!wide)
            return ACC_BYTE;
        else if (a0 && bhe_n)
            return ACC_SPLIT;
        else
            return ACC_LANES;
    endfunction

    function automatic int bank_depth(input int panel_w, input int panel_h);
        return (panel_w * panel_h) / (LANE_W * NUM_LANES);
    endfunction

endpackage

// File: rtl/vram_host_decode.sv
module vram_host_decode
    import vram_port_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       wide_mode,
    input  logic                       cs_n,
    input  logic                       rd_n,
    input  logic                       wrl_n,
    input  logic                       wrh_n,
    input  logic                       bhe_n,
    input  logic                       a0,
    input  logic [2*LANE_W-1:0]        wdata,
    output bank_req_t                  req_lo,
    output bank_req_t                  req_hi,
    output route_t                     route
);

    access_kind_e kind;
    logic         sel;
    logic         rd;

    always_comb begin
        kind = classify(wide_mode, a0, bhe_n);
        sel  = !cs_n;
        rd   = sel && !rd_n;

        req_lo     = '0;
        req_hi     = '0;
        route      = '0;
        req_lo.wd  = wdata[LANE_W-1:0];
        req_hi.wd  = wdata[2*LANE_W-1:LANE_W];

        unique case (kind)
            ACC_BYTE: begin
                req_hi.wd  = wdata[LANE_W-1:0];
                req_lo.we  = sel && !wrl_n && !a0;
                req_hi.we  = sel && !wrl_n && a0;
                req_lo.re  = rd && !a0;
                req_hi.re  = rd && a0;
                route.oe   = {1'b0, rd};
                route.swap = a0;
            end
            ACC_SPLIT: begin
                req_lo.we  = sel && !wrl_n;
                req_hi.we  = sel && !wrh_n;
                req_lo.re  = rd;
                req_hi.re  = rd;
                route.oe   = {rd, rd};
            end
            default: begin
                req_lo.we  = sel && !wrl_n && !a0;
                req_hi.we  = sel && !wrl_n && !bhe_n;
                req_lo.re  = rd && !a0;
                req_hi.re  = rd && !bhe_n;
                route.oe   = {rd && !bhe_n, rd && !a0};
            end
        endcase
    end

    // R2: a byte-wide host never writes both banks in one cycle
    p_byte_single_bank_r2: assert property (@(posedge clk) disable iff (rst)
        !wide_mode |-> $countones({req_lo.we, req_hi.we}) <= 1);

endmodule

// File: rtl/vram_bank.sv
module vram_bank
    import vram_port_pkg::*;
#(
    parameter int DEPTH  = 4800,
    parameter int WORD_W = 13,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] word,
    input  bank_req_t         req,
    output logic [LANE_W-1:0] q
);

    logic [LANE_W-1:0] mem [DEPTH];
    logic              in_range;
    logic [IDX_W-1:0]  idx;

    always_comb begin
        in_range = (32'(word) < DEPTH);
        idx      = word[IDX_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (req.we && in_range)
            mem[idx] <= req.wd;
    end

    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else if (req.re)
            q <= in_range ? mem[idx] : '0;
    end

endmodule

// File: rtl/vram_read_steer.sv
module vram_read_steer
    import vram_port_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  route_t                 route_in,
    input  logic [LANE_W-1:0]      q_lo,
    input  logic [LANE_W-1:0]      q_hi,
    output logic [2*LANE_W-1:0]    rdata,
    output logic [NUM_LANES-1:0]   lane_oe
);

    route_t route_q;

    always_ff @(posedge clk) begin
        if (rst)
            route_q <= '0;
        else
            route_q <= route_in;
    end

    always_comb begin
        lane_oe = route_q.oe;
        rdata   = '0;
        if (route_q.oe[0])
            rdata[LANE_W-1:0] = route_q.swap ? q_hi : q_lo;
        if (route_q.oe[1])
            rdata[2*LANE_W-1:LANE_W] = q_hi;
    end

endmodule

// File: rtl/dual_width_vram_port.sv
module dual_width_vram_port
    import vram_port_pkg::*;
#(
    parameter int PANEL_W = 320,
    parameter int PANEL_H = 240,
    parameter int ADDR_W  = 14,
    localparam int DEPTH  = bank_depth(PANEL_W, PANEL_H),
    localparam int WORD_W = ADDR_W - 1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wide_mode,
    input  logic                  cs_n,
    input  logic                  rd_n,
    input  logic                  wrl_n,
    input  logic                  wrh_n,
    input  logic                  bhe_n,
    input  logic [ADDR_W-1:0]     addr,
    input  logic [2*LANE_W-1:0]   wdata,
    output logic [2*LANE_W-1:0]   rdata,
    output logic [NUM_LANES-1:0]  lane_oe
);

    bank_req_t         req [NUM_LANES];
    logic [LANE_W-1:0] q   [NUM_LANES];
    route_t            route;
    logic [WORD_W-1:0] word;

    assign word = addr[ADDR_W-1:1];

    vram_host_decode u_decode (
        .clk       (clk),
        .rst       (rst),
        .wide_mode (wide_mode),
        .cs_n      (cs_n),
        .rd_n      (rd_n),
        .wrl_n     (wrl_n),
        .wrh_n     (wrh_n),
        .bhe_n     (bhe_n),
        .a0        (addr[0]),
        .wdata     (wdata),
        .req_lo    (req[0]),
        .req_hi    (req[1]),
        .route     (route)
    );

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_bank
        vram_bank #(
            .DEPTH  (DEPTH),
            .WORD_W (WORD_W)
        ) u_bank (
            .clk  (clk),
            .rst  (rst),
            .word (word),
            .req  (req[g]),
            .q    (q[g])
        );
    end

    vram_read_steer u_steer (
        .clk      (clk),
        .rst      (rst),
        .route_in (route),
        .q_lo     (q[0]),
        .q_hi     (q[1]),
        .rdata    (rdata),
        .lane_oe  (lane_oe)
    );

    // R7: a deselected cycle leaves no lane driven in the next cycle
    p_idle_no_drive_r7: assert property (@(posedge clk) disable iff (rst)
        $past(cs_n) |-> lane_oe == 2'b00);

    // R2: byte-wide read drives only the low lane
    p_byte_low_lane_r2: assert property (@(posedge clk) disable iff (rst)
        $past(!rst && !wide_mode && !cs_n && !rd_n) |-> lane_oe == 2'b01);

    // R6: split-strobe read drives both lanes
    p_split_both_lanes_r6: assert property (@(posedge clk) disable iff (rst)
        $past(!rst && wide_mode && !cs_n && !rd_n && addr[0] && bhe_n) |-> lane_oe == 2'b11);

    // R5: lane-select read drives exactly the requested lanes
    p_lane_select_oe_r5: assert property (@(posedge clk) disable iff (rst)
        $past(!rst && wide_mode && !cs_n && !rd_n && !(addr[0] && bhe_n))
            |-> lane_oe == {!$past(bhe_n), !$past(addr[0])});

endmodule

// File: tb/dual_width_vram_port_tb.sv
module dual_width_vram_port_tb;

    localparam int CLK_PERIOD = 10;
    localparam int PW = 32;
    localparam int PH = 8;
    localparam int NBYTES = PW * PH / 8;
    localparam int NWORDS = NBYTES / 2;

    logic        clk = 0;
    logic        rst;
    logic        wide_mode, cs_n, rd_n, wrl_n, wrh_n, bhe_n;
    logic [13:0] addr;
    logic [15:0] wdata;
    logic [15:0] rdata;
    logic [1:0]  lane_oe;

    int tests = 0;
    int fails = 0;
    bit done = 0;
    logic [7:0] model [NBYTES];

    always #(CLK_PERIOD/2) clk = ~clk;

    dual_width_vram_port #(.PANEL_W(PW), .PANEL_H(PH), .ADDR_W(14)) u_dut (
        .clk(clk), .rst(rst), .wide_mode(wide_mode), .cs_n(cs_n), .rd_n(rd_n),
        .wrl_n(wrl_n), .wrh_n(wrh_n), .bhe_n(bhe_n), .addr(addr),
        .wdata(wdata), .rdata(rdata), .lane_oe(lane_oe)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got %h exp %h", tag, got, exp);
        end
    endtask

    task automatic idle();
        cs_n = 1; rd_n = 1; wrl_n = 1; wrh_n = 1; bhe_n = 1;
        addr = '0; wdata = '0;
    endtask

    task automatic bus(input bit m, input bit cs, input int a, input bit bhe,
                       input bit wl, input bit wh, input bit rd, input logic [15:0] wd);
        wide_mode = m; cs_n = cs; addr = 14'(a); bhe_n = bhe;
        wrl_n = wl; wrh_n = wh; rd_n = rd; wdata = wd;
        @(posedge clk); @(negedge clk);
        idle();
    endtask

    function automatic logic [7:0] mbyte(input int b);
        return (b < NBYTES) ? model[b] : 8'h00;
    endfunction

    task automatic rd8(input string tag, input int b);
        bus(0, 0, b, 1, 1, 1, 0, 16'h0);
        chk({tag, " oe"}, 32'(lane_oe), 32'h1);
        chk({tag, " data"}, 32'(rdata), {24'h0, mbyte(b)});
    endtask

    task automatic rdw(input string tag, input int w, input bit a0, input bit bhe);
        logic [1:0] eoe;
        logic [15:0] ed;
        eoe = (a0 && bhe) ? 2'b11 : {!bhe, !a0};
        ed = {eoe[1] ? mbyte(2*w+1) : 8'h00, eoe[0] ? mbyte(2*w) : 8'h00};
        bus(1, 0, 2*w + int'(a0), bhe, 1, 1, 0, 16'h0);
        chk({tag, " oe"}, 32'(lane_oe), 32'(eoe));
        chk({tag, " data"}, 32'(rdata), 32'(ed));
    endtask

    initial begin
        wide_mode = 0; idle();
        rst = 1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 oe in reset", 32'(lane_oe), 32'h0);
        chk("R1 data in reset", 32'(rdata), 32'h0);
        rst = 0;
        @(posedge clk); @(negedge clk);
        chk("R1 oe after reset", 32'(lane_oe), 32'h0);

        // R2: byte-wide writes over the whole space, with bhe_n/wrh_n toggled (ignored)
        for (int b = 0; b < NBYTES + 8; b++) begin
            logic [7:0] d;
            d = 8'(b * 37 + 5);
            bus(0, 0, b, b[0] ? 1'b0 : 1'b1, 1'b0, b[0] ? 1'b0 : 1'b1, 1'b1, {~d, d});
            if (b < NBYTES) model[b] = d;
        end
        // R2 and R8: read back including out-of-range band
        for (int b = 0; b < NBYTES + 8; b++)
            rd8(b < NBYTES ? "R2 byte read" : "R8 byte out of range", b);

        // R3 and R6: wide split-strobe reads see the byte-wide contents
        for (int w = 0; w < NWORDS; w++) rdw("R3 shared word", w, 1, 1);

        // R4: lane-select writes, each lane pattern, read back as a full word
        for (int w = 0; w < NWORDS; w++) begin
            for (int s = 1; s < 4; s++) begin
                logic [15:0] d;
                d = 16'(w * 16'h1357 + s * 16'h2468);
                bus(1, 0, 2*w + (s[0] ? 0 : 1), s[1] ? 1'b0 : 1'b1, 0, 1, 1, d);
                if (s[0]) model[2*w] = d[7:0];
                if (s[1]) model[2*w+1] = d[15:8];
                rdw("R4 lane-select write", w, 0, 0);
            end
        end
        // R5: single-lane reads
        for (int w = 0; w < NWORDS; w++) begin
            rdw("R5 low lane only", w, 0, 1);
            rdw("R5 high lane only", w, 1, 0);
        end

        // R6: split strobes, independently and together
        for (int w = 0; w < NWORDS; w++) begin
            for (int s = 1; s < 4; s++) begin
                logic [15:0] d;
                d = 16'(w * 16'h0f1d + s * 16'h3c5a);
                bus(1, 0, 2*w + 1, 1, s[0] ? 1'b0 : 1'b1, s[1] ? 1'b0 : 1'b1, 1, d);
                if (s[0]) model[2*w] = d[7:0];
                if (s[1]) model[2*w+1] = d[15:8];
                rdw("R6 split write", w, 1, 1);
            end
        end

        // R7: deselected strobes write nothing and drive nothing
        bus(1, 1, 2*5 + 1, 1, 0, 0, 0, 16'hdead);
        chk("R7 oe when deselected", 32'(lane_oe), 32'h0);
        chk("R7 data when deselected", 32'(rdata), 32'h0);
        bus(0, 1, 7, 1, 0, 1, 0, 16'h00ee);
        chk("R7 oe byte deselected", 32'(lane_oe), 32'h0);
        rdw("R7 word unchanged", 5, 1, 1);
        rd8("R7 byte unchanged", 7);

        // R8: wide out-of-range writes drop, reads give zero
        bus(1, 0, 2*(NWORDS + 2) + 1, 1, 0, 0, 1, 16'hbeef);
        rdw("R8 wide out of range", NWORDS + 2, 1, 1);
        for (int w = 0; w < NWORDS; w++) rdw("R8 in-range intact", w, 1, 1);

        // R9: read and write of the same word in one cycle
        begin
            logic [15:0] old;
            old = {model[7], model[6]};
            bus(1, 0, 7, 1, 0, 0, 0, 16'h5aa5);
            chk("R9 old data on collision", 32'(rdata), 32'(old));
            chk("R9 oe on collision", 32'(lane_oe), 32'h3);
            model[6] = 8'ha5; model[7] = 8'h5a;
            rdw("R9 new data after collision", 3, 1, 1);
        end

        // R10: output timing around a read
        @(negedge clk);
        chk("R10 idle before read", 32'(lane_oe), 32'h0);
        wide_mode = 0; cs_n = 0; rd_n = 0; addr = 14'd9; bhe_n = 1;
        #1;
        chk("R10 no change before edge", 32'(lane_oe), 32'h0);
        @(posedge clk); @(negedge clk);
        idle();
        chk("R10 oe after edge", 32'(lane_oe), 32'h1);
        chk("R10 data after edge", 32'(rdata), {24'h0, model[9]});
        @(posedge clk); @(negedge clk);
        chk("R10 oe released", 32'(lane_oe), 32'h0);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog expired got %0d exp %0d", 0, 1);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule